// File: doc/BRIEF.md
# Line-scan sensor serial controller

This block drives a serial line-scan image sensor of 102 pixels from inside an FPGA. A free-running line timer, reloaded from a programmable period counted in system-clock cycles, starts each acquisition. At 48 MHz a period of 30240 gives about 630 µs per line, or roughly 1600 lines per second. When a line starts, the block plays a command sequence out of a bit-addressed on-chip memory and sends it to the sensor's serial input. Each sensor command is an 8-bit instruction, so the sequence is a whole number of bytes.

After the commands, the block listens on the sensor's serial output for a start condition, which is the line going low. It then collects the pixel bitstream into bytes and writes each completed byte back into the same memory, in a region starting at bit address 512. One address counter serves both the command read and the pixel write. The byte write strobe is decoded from the counter's low three bits.

If no start condition arrives within a fixed number of serial bits, the line is abandoned and a sticky error flag is raised. The serial clock is the system clock divided down.

Top module: `linescan_ctrl`

## Requirements
- R1: While `rstN` is low, `memAddr`, `sdo`, `memWe`, `errFlag` and `sclk` are all 0. The line timer also clears, so the first line begins right after reset is released.
- R2: A line begins only when the line timer expires while the block is idle. The timer reloads from `linePeriod` at every expiry, so line starts are a whole multiple of `linePeriod` cycles apart. When acquisition is shorter than the period, the spacing is exactly `linePeriod`.
- R3: A timer expiry that lands while a line is still in progress is ignored. The next line waits for the first expiry after the block returns to idle.
- R4: Each line sends `CMD_BITS` (default 24) bits taken from memory bit addresses 0, 1, 2 … in ascending order, one bit per `sclk` period. `sclk` has a period of 2·`SCLK_HALF` system cycles. `sdo` changes only while `sclk` is low and holds steady across every rising edge of `sclk`.
- R5: After the last command bit, `sdo` returns to 0. The block then samples `sdi` on each rising `sclk` edge until it sees a 0, which is the start condition.
- R6: The bits after the start condition are packed least significant bit first, 8 bits to a byte. Each completed byte appears on `memWdata`.
- R7: `memWe` is a one-cycle pulse, issued only when the low three bits of `memAddr` are 0. For the k-th byte of a line (k counted from 0), `memAddr` = 512 + 8·(k+1). Every successful line produces exactly 102 writes, and the block then returns to idle.
- R8: If `TMO_BITS` (default 64) consecutive samples are high, the line is abandoned with no writes and `errFlag` is set. A start condition after `TMO_BITS`−1 high samples is still accepted.
- R9: `errFlag` stays at 1 until reset, and later lines still acquire normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| linePeriod | input | 16 | Line period in system cycles (at least 2) |
| cmdBit | input | 1 | Memory read data: the bit at `memAddr` |
| sdi | input | 1 | Serial data from the sensor |
| memAddr | output | 11 | Shared bit address for command read and pixel write |
| memWe | output | 1 | Byte write strobe |
| memWdata | output | 8 | Completed pixel byte |
| sclk | output | 1 | Serial clock to the sensor |
| sdo | output | 1 | Serial command data to the sensor |
| errFlag | output | 1 | Sticky start-condition timeout flag |

## Verification
The line timer and the capture engine can act in the same cycle: the timer can expire while a capture is still writing bytes. The bench provokes this by shortening `linePeriod` to 2000 cycles, well below the roughly 3400 cycles a capture needs, while the sensor model keeps answering. The outcome is judged in two ways. First, each such line must still deliver all 102 bytes at the expected addresses with no command bits interleaved. Second, the next first command edge must come exactly one full 4000-cycle reload sequence later, which shows that the mid-capture expiry was dropped.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
  localparam int ADDR_W    = 11;
  localparam int TMR_W     = 16;
  localparam int CMD_BITS  = 24;
  localparam int CAP_BASE  = 512;
  localparam int PIX_BYTES = 102;
  localparam int TMO_BITS  = 64;
  localparam int SCLK_HALF = 2;

  typedef struct packed {
    logic addrZero;
    logic addrCap;
    logic addrInc;
    logic sdoLoad;
    logic sdoZero;
    logic shiftEn;
    logic clkRun;
  } dpCtrl_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_WAIT = 2'd2,
    ST_CAPT = 2'd3
  } scanState_t;
endpackage

// File: rtl/lsc_datapath.sv
module lsc_datapath
  import lsc_pkg::*;
#(
  parameter int ADDR_W    = lsc_pkg::ADDR_W,
  parameter int TMR_W     = lsc_pkg::TMR_W,
  parameter int CMD_BITS  = lsc_pkg::CMD_BITS,
  parameter int CAP_BASE  = lsc_pkg::CAP_BASE,
  parameter int SCLK_HALF = lsc_pkg::SCLK_HALF
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           ctrl,
  input  logic [TMR_W-1:0]  linePeriod,
  input  logic              cmdBit,
  input  logic              sdi,
  output logic              lineExpire,
  output logic              riseTick,
  output logic              fallTick,
  output logic              cmdDone,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWe,
  output logic [7:0]        memWdata,
  output logic              sclk,
  output logic              sdo
);
  localparam int DIV_W = (SCLK_HALF > 1) ? $clog2(SCLK_HALF) : 1;
  localparam logic [DIV_W-1:0]  DIV_LAST = DIV_W'(SCLK_HALF - 1);
  localparam logic [ADDR_W-1:0] CMD_END  = ADDR_W'(CMD_BITS);
  localparam logic [ADDR_W-1:0] CAP_ADDR = ADDR_W'(CAP_BASE);

  logic [TMR_W-1:0]  lineTmr;
  logic [DIV_W-1:0]  divCnt;
  logic [ADDR_W-1:0] addrQ;
  logic [7:0]        shiftQ;
  logic [7:0]        nextByte;
  logic              divWrap;

  // Line timer: free running, reloads on expiry.
  assign lineExpire = (lineTmr == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           lineTmr <= '0;
    else if (lineExpire) lineTmr <= linePeriod - TMR_W'(1);
    else                 lineTmr <= lineTmr - TMR_W'(1);
  end

  // Serial clock divider, held low while idle.
  assign divWrap  = ctrl.clkRun && (divCnt == DIV_LAST);
  assign riseTick = divWrap && !sclk;
  assign fallTick = divWrap && sclk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
      sclk   <= 1'b0;
    end else if (!ctrl.clkRun) begin
      divCnt <= '0;
      sclk   <= 1'b0;
    end else if (divWrap) begin
      divCnt <= '0;
      sclk   <= ~sclk;
    end else begin
      divCnt <= divCnt + DIV_W'(1);
    end
  end

  // Shared bit-address counter.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              addrQ <= '0;
    else if (ctrl.addrZero) addrQ <= '0;
    else if (ctrl.addrCap)  addrQ <= CAP_ADDR;
    else if (ctrl.addrInc)  addrQ <= addrQ + ADDR_W'(1);
  end

  assign memAddr = addrQ;
  assign cmdDone = (addrQ == CMD_END);

  // Command output bit.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             sdo <= 1'b0;
    else if (ctrl.sdoZero) sdo <= 1'b0;
    else if (ctrl.sdoLoad) sdo <= cmdBit;
  end

  // Pixel shift register, LSB first; write on byte boundary of the address.
  assign nextByte = {sdi, shiftQ[7:1]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ   <= '0;
      memWe    <= 1'b0;
      memWdata <= '0;
    end else begin
      memWe <= ctrl.shiftEn && (addrQ[2:0] == 3'd7);
      if (ctrl.shiftEn) begin
        shiftQ <= nextByte;
        if (addrQ[2:0] == 3'd7) memWdata <= nextByte;
      end
    end
  end
endmodule

// File: rtl/lsc_control.sv
module lsc_control
  import lsc_pkg::*;
#(
  parameter int PIX_BYTES = lsc_pkg::PIX_BYTES,
  parameter int TMO_BITS  = lsc_pkg::TMO_BITS
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    lineExpire,
  input  logic    riseTick,
  input  logic    fallTick,
  input  logic    cmdDone,
  input  logic    byteWritten,
  input  logic    sdi,
  output dpCtrl_t ctrl,
  output logic    errFlag
);
  localparam int TMO_W  = $clog2(TMO_BITS + 1);
  localparam int BYTE_W = $clog2(PIX_BYTES + 1);
  localparam logic [TMO_W-1:0]  TMO_LAST  = TMO_W'(TMO_BITS - 1);
  localparam logic [BYTE_W-1:0] BYTE_LAST = BYTE_W'(PIX_BYTES - 1);

  scanState_t        state, nextState;
  logic [TMO_W-1:0]  tmoCnt;
  logic [BYTE_W-1:0] byteCnt;
  logic              errSet;

  always_comb begin
    ctrl      = '0;
    nextState = state;
    errSet    = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (lineExpire) begin
          ctrl.sdoLoad = 1'b1;
          ctrl.addrInc = 1'b1;
          nextState    = ST_SEND;
        end
      end
      ST_SEND: begin
        ctrl.clkRun = 1'b1;
        if (fallTick) begin
          if (cmdDone) begin
            ctrl.sdoZero = 1'b1;
            ctrl.addrCap = 1'b1;
            nextState    = ST_WAIT;
          end else begin
            ctrl.sdoLoad = 1'b1;
            ctrl.addrInc = 1'b1;
          end
        end
      end
      ST_WAIT: begin
        ctrl.clkRun = 1'b1;
        if (riseTick) begin
          if (!sdi) begin
            nextState = ST_CAPT;
          end else if (tmoCnt == TMO_LAST) begin
            errSet        = 1'b1;
            ctrl.addrZero = 1'b1;
            nextState     = ST_IDLE;
          end
        end
      end
      ST_CAPT: begin
        ctrl.clkRun = 1'b1;
        if (riseTick) begin
          ctrl.shiftEn = 1'b1;
          ctrl.addrInc = 1'b1;
        end
        if (byteWritten && byteCnt == BYTE_LAST) begin
          ctrl.addrZero = 1'b1;
          nextState     = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      tmoCnt  <= '0;
      byteCnt <= '0;
      errFlag <= 1'b0;
    end else begin
      state <= nextState;
      if (errSet) errFlag <= 1'b1;
      if (state != ST_WAIT)             tmoCnt <= '0;
      else if (riseTick && sdi)         tmoCnt <= tmoCnt + TMO_W'(1);
      if (state != ST_CAPT)             byteCnt <= '0;
      else if (byteWritten)             byteCnt <= byteCnt + BYTE_W'(1);
    end
  end
endmodule

// File: rtl/linescan_ctrl.sv
module linescan_ctrl
  import lsc_pkg::*;
#(
  parameter int ADDR_W    = lsc_pkg::ADDR_W,
  parameter int TMR_W     = lsc_pkg::TMR_W,
  parameter int CMD_BITS  = lsc_pkg::CMD_BITS,
  parameter int CAP_BASE  = lsc_pkg::CAP_BASE,
  parameter int PIX_BYTES = lsc_pkg::PIX_BYTES,
  parameter int TMO_BITS  = lsc_pkg::TMO_BITS,
  parameter int SCLK_HALF = lsc_pkg::SCLK_HALF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [TMR_W-1:0]  linePeriod,
  input  logic              cmdBit,
  input  logic              sdi,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWe,
  output logic [7:0]        memWdata,
  output logic              sclk,
  output logic              sdo,
  output logic              errFlag
);
  dpCtrl_t ctrl;
  logic    lineExpire, riseTick, fallTick, cmdDone;

  lsc_datapath #(
    .ADDR_W(ADDR_W), .TMR_W(TMR_W), .CMD_BITS(CMD_BITS),
    .CAP_BASE(CAP_BASE), .SCLK_HALF(SCLK_HALF)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .linePeriod(linePeriod),
    .cmdBit(cmdBit), .sdi(sdi), .lineExpire(lineExpire),
    .riseTick(riseTick), .fallTick(fallTick), .cmdDone(cmdDone),
    .memAddr(memAddr), .memWe(memWe), .memWdata(memWdata),
    .sclk(sclk), .sdo(sdo)
  );

  lsc_control #(
    .PIX_BYTES(PIX_BYTES), .TMO_BITS(TMO_BITS)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .lineExpire(lineExpire),
    .riseTick(riseTick), .fallTick(fallTick), .cmdDone(cmdDone),
    .byteWritten(memWe), .sdi(sdi), .ctrl(ctrl), .errFlag(errFlag)
  );
endmodule

// File: rtl/lsc_checker.sv
module lsc_checker
  import lsc_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memWe,
  input logic              sclk,
  input logic              sdo,
  input logic              errFlag
);
  // R7: writes land on byte boundaries inside the capture region
  p_we_aligned_r7: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> (memAddr[2:0] == 3'b000 && memAddr > ADDR_W'(CAP_BASE)));

  // R7: the strobe lasts one cycle
  p_we_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    memWe |=> !memWe);

  // R6: a byte is written right after a sampling edge, while sclk is high
  p_we_after_rise_r6: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> sclk);

  // R9: the error flag never drops without reset
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag);

  // R4: command data holds steady across each rising serial clock edge
  p_sdo_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sclk) |-> $stable(sdo));
endmodule

bind linescan_ctrl lsc_checker u_chk (
  .clk(clk), .rstN(rstN), .memAddr(memAddr), .memWe(memWe),
  .sclk(sclk), .sdo(sdo), .errFlag(errFlag)
);

// File: tb/linescan_ctrl_test.sv
module linescan_ctrl_test;
  import lsc_pkg::*;

  localparam int NLINES = 9;
  localparam logic [CMD_BITS-1:0] CMD_PAT = 24'hA53C96;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [TMR_W-1:0]  linePeriod = 16'd4000;
  logic              cmdBit;
  logic              sdi = 1'b1;
  logic [ADDR_W-1:0] memAddr;
  logic              memWe;
  logic [7:0]        memWdata;
  logic              sclk, sdo, errFlag;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int wrCount = 0;
  bit done = 1'b0;
  logic [7:0] expQ[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc++;

  // Bit-addressed command memory model
  assign cmdBit = (memAddr < ADDR_W'(CMD_BITS)) ? CMD_PAT[memAddr[4:0]] : 1'b0;

  linescan_ctrl uut (
    .clk(clk), .rstN(rstN), .linePeriod(linePeriod), .cmdBit(cmdBit),
    .sdi(sdi), .memAddr(memAddr), .memWe(memWe), .memWdata(memWdata),
    .sclk(sclk), .sdo(sdo), .errFlag(errFlag)
  );

  task automatic check(string tag, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic finishRun();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // Every-clock comparison of the write port against the reference queue
  always @(negedge clk) begin
    if (rstN && memWe) begin
      check("R7 write address", memAddr, CAP_BASE + 8 * (wrCount + 1));
      if (expQ.size() == 0) check("R6 unexpected write", 1, 0);
      else check("R6 byte data", memWdata, expQ.pop_front());
      wrCount++;
    end
  end

  // Reset and behavioural sensor model
  initial begin
    int delays[NLINES] = '{0, 5, TMO_BITS - 1, -1, 2, 1, 0, 3, 0};
    int prevStart = 0;
    int prevExpWr = 0;
    repeat (3) @(negedge clk);
    check("R1 memAddr in reset", memAddr, 0);
    check("R1 sdo in reset", sdo, 0);
    check("R1 memWe in reset", memWe, 0);
    check("R1 errFlag in reset", errFlag, 0);
    check("R1 sclk in reset", sclk, 0);
    rstN = 1'b1;
    for (int ln = 0; ln < NLINES; ln++) begin
      logic [CMD_BITS-1:0] got;
      @(posedge sclk);
      if (ln == 0) check("R1 first line right after reset", (cyc < 10) ? 1 : 0, 1);
      else begin
        // R2 spacing; for lines 7 and 8 the mid-capture expiry must be skipped (R3)
        check((ln >= 7) ? "R3 period after ignored expiry" : "R2 line period",
              cyc - prevStart, 4000);
        check("R7 writes per line", wrCount, prevExpWr);
      end
      prevStart = cyc;
      wrCount = 0;
      if (ln == 5) linePeriod = 16'd2000;
      if (ln == 3) check("R9 flag clear before timeout", errFlag, 0);
      if (ln >= 4) check("R9 flag held after timeout", errFlag, 1);
      got[0] = sdo;
      for (int i = 1; i < CMD_BITS; i++) begin
        @(posedge sclk);
        got[i] = sdo;
      end
      check("R4 command bits", got, CMD_PAT);
      if (delays[ln] < 0) begin
        int r = 0;
        do begin
          @(posedge sclk);
          r++;
          #1;
          if (r == 1) check("R5 sdo low while waiting", sdo, 0);
        end while (!errFlag && r < 200);
        check("R8 timeout after high samples", r, TMO_BITS);
        prevExpWr = 0;
      end else begin
        repeat (delays[ln]) begin
          @(negedge sclk);
          @(posedge sclk);
        end
        @(negedge sclk);
        sdi <= 1'b0;
        @(posedge sclk);
        for (int k = 0; k < PIX_BYTES; k++) begin
          logic [7:0] b;
          b = 8'((ln * 37 + k * 11 + 3) & 255);
          expQ.push_back(b);
          for (int j = 0; j < 8; j++) begin
            @(negedge sclk);
            sdi <= b[j];
            @(posedge sclk);
          end
        end
        sdi <= 1'b1;
        prevExpWr = PIX_BYTES;
      end
    end
    repeat (600) @(posedge clk);
    @(negedge clk);
    check("R7 writes on last line", wrCount, prevExpWr);
    check("R7 all expected bytes written", expQ.size(), 0);
    check("R9 flag still set at end", errFlag, 1);
    done = 1'b1;
    finishRun();
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finishRun();
    end
  end
endmodule